// File: doc/BRIEF.md
# Multichannel DMA Register Programming Port

This block is the host-facing programming front end of an eight-channel DMA controller. The host reaches it through two byte-wide I/O locations. A write to the function location selects an operation and a channel. Accesses to the execute location then carry that operation's operands, one byte per access. The block keeps the following state for each channel: a 24-bit memory address, a 16-bit transfer count, a 16-bit I/O target port, a mode byte and a mask bit. It returns the address, the count and a terminal-count status byte on reads.

The stored count is one less than the number of transfers wanted. A per-channel progress strobe stands in for the data mover. On each accepted strobe the count steps down and the address steps up. When the count passes zero it wraps to all ones and records a terminal-count flag for that channel. The mode, port and mask values are driven out as registered outputs for the transfer engine to use.

Top module: `dma_prog_port`

## Requirements
- R1: A write to offset 0x18 latches the operation from data bits [7:4] and the channel from bits [2:0]. Bit 3 is ignored. The write also sets the execute byte pointer back to the first byte.
- R2: Operation 0x2 loads the 24-bit address through three execute writes at offset 0x1A, least significant byte first. Operation 0x3 returns the address through three execute reads in the same order. `io_rdata` holds the byte in the cycle after the read strobe.
- R3: Operation 0x4 loads the 16-bit count through two execute writes, low byte first. Operation 0x5 reads the stored value back in the same order.
- R4: Operation 0x0 loads the 16-bit I/O target port through two execute writes, low byte first. The value appears on that channel's `ch_iop` slice (bits c*16 upward).
- R5: Operation 0x7 stores one execute byte as the channel mode, shown on `ch_mode` bits c*8 upward. Mode bit 2 (0x04) enables transfers, 0x08 reverses the direction, 0x01 selects an I/O-port target and 0x40 selects 16-bit transfers.
- R6: Operation 0x9 sets and operation 0xA clears that channel's `ch_mask` bit on the function write alone. No execute access is needed.
- R7: The following execute accesses change no state: accesses beyond a field's byte width, writes under a read-type or operand-less operation (0x3, 0x5, 0x6, 0x8, 0x9, 0xA, 0xD, undefined codes), and reads under a write-type operation. Such a read returns 0x00.
- R8: Operation 0xD (master clear) sets every mask bit. It also zeroes every address, count, port and mode register, and clears all terminal-count flags.
- R9: A strobe on `xfer_tick[c]` acts only when the channel is unmasked and mode bit 2 is set. It then decrements the count and increments the address modulo 2^24. A masked or disabled channel keeps both values unchanged.
- R10: A strobe on a stored count of 0 wraps the count to 0xFFFF and sets terminal-count flag c. A stored N therefore reaches the flag on strobe N+1.
- R11: Operation 0x6 returns the flags as one byte, bit c for channel c, and clears them on that read. A flag raised in the same cycle as the read survives it. A second read returns 0x00.
- R12: After reset all masks are 1, all registers and `io_rdata` are zero, and no operation is selected. Execute accesses made before the first function write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O offset of the access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| xfer_tick | input | 8 | Per-channel transfer progress strobe |
| ch_mask | output | 8 | Per-channel mask bits |
| ch_mode | output | 64 | Mode byte of each channel, channel c at bits c*8 |
| ch_iop | output | 128 | I/O target port of each channel, channel c at bits c*16 |

## Verification
The hardest case to reach is a count wrapping to 0xFFFF in the same cycle that the status byte is read and cleared. If the order is wrong, the new flag is lost. The stimulus programs a small count, enables and unmasks the channel, and lines one strobe up exactly with the status read. A further status read then confirms that the flag survived. A long mixed run of random function codes, operand bytes, reads and strobes is checked against a behavioural model on every clock. That run covers undefined codes and accesses past a field's width.

// File: rtl/dma_prog_pkg.sv
`timescale 1ns/1ps
package dma_prog_pkg;
  typedef enum logic [3:0] {
    OP_SET_IOP  = 4'h0,
    OP_SET_ADDR = 4'h2,
    OP_GET_ADDR = 4'h3,
    OP_SET_CNT  = 4'h4,
    OP_GET_CNT  = 4'h5,
    OP_GET_STAT = 4'h6,
    OP_SET_MODE = 4'h7,
    OP_SET_ARB  = 4'h8,
    OP_MASK     = 4'h9,
    OP_UNMASK   = 4'hA,
    OP_MCLR     = 4'hD,
    OP_NONE     = 4'hF
  } dma_op_e;

  localparam int BYTE_W     = 8;
  localparam int MODE_EN_IX = 2;
endpackage

// File: rtl/dma_fn_ctrl.sv
`timescale 1ns/1ps
module dma_fn_ctrl
  import dma_prog_pkg::*;
#(
  parameter int                PORT_AW = 8,
  parameter logic [PORT_AW-1:0] FN_OFS  = 8'h18,
  parameter logic [PORT_AW-1:0] EXE_OFS = 8'h1A,
  parameter int                CH_W    = 3,
  parameter int                PTR_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PORT_AW-1:0] io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [BYTE_W-1:0]  io_wdata,
  output dma_op_e            op_o,
  output logic [CH_W-1:0]    ch_o,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               fn_wr_o,
  output dma_op_e            fn_op_o,
  output logic [CH_W-1:0]    fn_ch_o,
  output logic               exe_wr_o,
  output logic               exe_rd_o
);
  dma_op_e           op_q;
  logic [CH_W-1:0]   ch_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              fn_wr, exe_wr, exe_rd;
  logic              fn_unused;

  assign fn_wr   = io_wr && (io_addr == FN_OFS);
  assign exe_wr  = io_wr && (io_addr == EXE_OFS);
  assign exe_rd  = io_rd && !io_wr && (io_addr == EXE_OFS);
  assign fn_op_o = dma_op_e'(io_wdata[7:4]);
  assign fn_ch_o = io_wdata[CH_W-1:0];
  assign fn_unused = ^io_wdata[3:CH_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_NONE;
      ch_q  <= '0;
      ptr_q <= '0;
    end else if (fn_wr) begin
      op_q  <= fn_op_o;
      ch_q  <= fn_ch_o;
      ptr_q <= '0;
    end else if ((exe_wr || exe_rd) && (ptr_q != '1)) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign op_o     = op_q;
  assign ch_o     = ch_q;
  assign ptr_o    = ptr_q;
  assign fn_wr_o  = fn_wr;
  assign exe_wr_o = exe_wr;
  assign exe_rd_o = exe_rd;

  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (rst)
    fn_wr |=> (ptr_q == '0)); // R1
  AST_PTR_PARKED: assert property (@(posedge clk) disable iff (rst)
    ((ptr_q == '1) && !fn_wr) |=> (ptr_q == '1)); // R7
endmodule

// File: rtl/dma_chan_reg.sv
`timescale 1ns/1ps
module dma_chan_reg
  import dma_prog_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int IOP_W  = 16,
  localparam int AB    = ADDR_W / BYTE_W,
  localparam int CB    = CNT_W / BYTE_W,
  localparam int IB    = IOP_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr_i,
  input  logic [AB-1:0]     addr_be_i,
  input  logic [CB-1:0]     cnt_be_i,
  input  logic [IB-1:0]     iop_be_i,
  input  logic              mode_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  input  logic              tick_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [IOP_W-1:0]  iop_o,
  output logic [BYTE_W-1:0] mode_o,
  output logic              mask_o,
  output logic              tc_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IOP_W-1:0]  iop_q;
  logic [BYTE_W-1:0] mode_q;
  logic              mask_q;
  logic              step;

  assign step = tick_i && !mask_q && mode_q[MODE_EN_IX];

  always_ff @(posedge clk) begin
    if (rst || mclr_i) begin
      addr_q <= '0;
      cnt_q  <= '0;
      iop_q  <= '0;
      mode_q <= '0;
      mask_q <= 1'b1;
    end else begin
      if (|addr_be_i) begin
        for (int b = 0; b < AB; b++)
          if (addr_be_i[b]) addr_q[b*BYTE_W +: BYTE_W] <= wdata_i;
      end else if (step) begin
        addr_q <= addr_q + 1'b1;
      end
      if (|cnt_be_i) begin
        for (int b = 0; b < CB; b++)
          if (cnt_be_i[b]) cnt_q[b*BYTE_W +: BYTE_W] <= wdata_i;
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end
      for (int b = 0; b < IB; b++)
        if (iop_be_i[b]) iop_q[b*BYTE_W +: BYTE_W] <= wdata_i;
      if (mode_we_i) mode_q <= wdata_i;
      if (mask_set_i)      mask_q <= 1'b1;
      else if (mask_clr_i) mask_q <= 1'b0;
    end
  end

  assign tc_o   = step && (cnt_be_i == '0) && (cnt_q == '0) && !mclr_i;
  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign iop_o  = iop_q;
  assign mode_o = mode_q;
  assign mask_o = mask_q;

  AST_MCLR_STATE: assert property (@(posedge clk) disable iff (rst)
    mclr_i |=> (mask_q && (cnt_q == '0) && (addr_q == '0) && (mode_q == '0) && (iop_q == '0))); // R8
  AST_MASK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (tick_i && mask_q && !mclr_i && (addr_be_i == '0) && (cnt_be_i == '0))
      |=> ($stable(cnt_q) && $stable(addr_q))); // R9
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !mask_q && mode_q[MODE_EN_IX] && !mclr_i && (cnt_be_i == '0) && (cnt_q != '0))
      |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R9
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !mask_q && mode_q[MODE_EN_IX] && !mclr_i && (cnt_be_i == '0) && (cnt_q == '0))
      |=> (&cnt_q)); // R10
endmodule

// File: rtl/dma_rd_mux.sv
`timescale 1ns/1ps
module dma_rd_mux
  import dma_prog_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int CH_W   = 3,
  parameter int PTR_W  = 2,
  localparam int AB    = ADDR_W / BYTE_W,
  localparam int CB    = CNT_W / BYTE_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_i,
  input  logic                         exe_rd_i,
  input  dma_op_e                      op_i,
  input  logic [CH_W-1:0]              ch_i,
  input  logic [PTR_W-1:0]             ptr_i,
  input  logic [NCH-1:0][ADDR_W-1:0]   addr_i,
  input  logic [NCH-1:0][CNT_W-1:0]    cnt_i,
  input  logic [NCH-1:0]               stat_i,
  output logic [BYTE_W-1:0]            rdata_o
);
  logic [ADDR_W-1:0] a_sh;
  logic [CNT_W-1:0]  c_sh;
  logic [BYTE_W-1:0] nxt;
  logic [BYTE_W-1:0] rdata_q;

  assign a_sh = addr_i[ch_i] >> (BYTE_W * int'(ptr_i));
  assign c_sh = cnt_i[ch_i]  >> (BYTE_W * int'(ptr_i));

  always_comb begin
    nxt = '0;
    if (exe_rd_i) begin
      unique case (op_i)
        OP_GET_ADDR: if (int'(ptr_i) < AB) nxt = a_sh[BYTE_W-1:0];
        OP_GET_CNT:  if (int'(ptr_i) < CB) nxt = c_sh[BYTE_W-1:0];
        OP_GET_STAT: if (ptr_i == '0)      nxt = BYTE_W'(stat_i);
        default:     nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= nxt;
  end

  assign rdata_o = rdata_q;

  AST_RD_BEYOND: assert property (@(posedge clk) disable iff (rst)
    (exe_rd_i && (int'(ptr_i) >= AB)) |=> (rdata_o == '0)); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o)); // R2
endmodule

// File: rtl/dma_prog_port.sv
`timescale 1ns/1ps
module dma_prog_port
  import dma_prog_pkg::*;
#(
  parameter int                 NCH     = 8,
  parameter int                 ADDR_W  = 24,
  parameter int                 CNT_W   = 16,
  parameter int                 IOP_W   = 16,
  parameter int                 PORT_AW = 8,
  parameter logic [PORT_AW-1:0] FN_OFS  = 8'h18,
  parameter logic [PORT_AW-1:0] EXE_OFS = 8'h1A
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PORT_AW-1:0]   io_addr,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [7:0]           io_wdata,
  output logic [7:0]           io_rdata,
  input  logic [NCH-1:0]       xfer_tick,
  output logic [NCH-1:0]       ch_mask,
  output logic [NCH*8-1:0]     ch_mode,
  output logic [NCH*IOP_W-1:0] ch_iop
);
  localparam int CH_W  = $clog2(NCH);
  localparam int AB    = ADDR_W / BYTE_W;
  localparam int CB    = CNT_W / BYTE_W;
  localparam int IB    = IOP_W / BYTE_W;
  localparam int PTR_W = $clog2(AB + 1);

  dma_op_e           op_q, fn_op;
  logic [CH_W-1:0]   ch_q, fn_ch;
  logic [PTR_W-1:0]  ptr_q;
  logic              fn_wr, exe_wr, exe_rd, mclr, stat_rd;

  logic [NCH-1:0][ADDR_W-1:0] addr_arr;
  logic [NCH-1:0][CNT_W-1:0]  cnt_arr;
  logic [NCH-1:0]             tc_vec;
  logic [NCH-1:0]             tc_q;

  dma_fn_ctrl #(
    .PORT_AW(PORT_AW), .FN_OFS(FN_OFS), .EXE_OFS(EXE_OFS),
    .CH_W(CH_W), .PTR_W(PTR_W)
  ) u_fn (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .op_o(op_q), .ch_o(ch_q), .ptr_o(ptr_q),
    .fn_wr_o(fn_wr), .fn_op_o(fn_op), .fn_ch_o(fn_ch),
    .exe_wr_o(exe_wr), .exe_rd_o(exe_rd)
  );

  assign mclr    = fn_wr && (fn_op == OP_MCLR);
  assign stat_rd = exe_rd && (op_q == OP_GET_STAT) && (ptr_q == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          hit;
    logic [AB-1:0] abe;
    logic [CB-1:0] cbe;
    logic [IB-1:0] ibe;
    logic          mwe, mset, mclr_ch;

    assign hit = (ch_q == CH_W'(c));

    always_comb begin
      abe = '0;
      cbe = '0;
      ibe = '0;
      for (int b = 0; b < AB; b++)
        abe[b] = exe_wr && hit && (op_q == OP_SET_ADDR) && (int'(ptr_q) == b);
      for (int b = 0; b < CB; b++)
        cbe[b] = exe_wr && hit && (op_q == OP_SET_CNT) && (int'(ptr_q) == b);
      for (int b = 0; b < IB; b++)
        ibe[b] = exe_wr && hit && (op_q == OP_SET_IOP) && (int'(ptr_q) == b);
    end

    assign mwe     = exe_wr && hit && (op_q == OP_SET_MODE) && (ptr_q == '0);
    assign mset    = fn_wr && (fn_op == OP_MASK)   && (fn_ch == CH_W'(c));
    assign mclr_ch = fn_wr && (fn_op == OP_UNMASK) && (fn_ch == CH_W'(c));

    dma_chan_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IOP_W(IOP_W)) u_reg (
      .clk(clk), .rst(rst), .mclr_i(mclr),
      .addr_be_i(abe), .cnt_be_i(cbe), .iop_be_i(ibe), .mode_we_i(mwe),
      .wdata_i(io_wdata), .mask_set_i(mset), .mask_clr_i(mclr_ch),
      .tick_i(xfer_tick[c]),
      .addr_o(addr_arr[c]), .cnt_o(cnt_arr[c]),
      .iop_o(ch_iop[c*IOP_W +: IOP_W]), .mode_o(ch_mode[c*8 +: 8]),
      .mask_o(ch_mask[c]), .tc_o(tc_vec[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || mclr) tc_q <= '0;
    else             tc_q <= (stat_rd ? '0 : tc_q) | tc_vec;
  end

  dma_rd_mux #(
    .NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CH_W(CH_W), .PTR_W(PTR_W)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_i(io_rd && !io_wr), .exe_rd_i(exe_rd),
    .op_i(op_q), .ch_i(ch_q), .ptr_i(ptr_q),
    .addr_i(addr_arr), .cnt_i(cnt_arr), .stat_i(tc_q), .rdata_o(io_rdata)
  );

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && (tc_vec == '0)) |=> (tc_q == '0)); // R11
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!stat_rd && !mclr) |=> ((tc_q & $past(tc_q)) == $past(tc_q))); // R10
  AST_UNMASK_FN: assert property (@(posedge clk) disable iff (rst)
    (fn_wr && (fn_op == OP_UNMASK)) |=> !ch_mask[$past(fn_ch)]); // R6
endmodule

// File: tb/dma_prog_port_tb.sv
`timescale 1ns/1ps
module dma_prog_port_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   io_addr = '0;
  logic         io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]   io_wdata = '0;
  logic [7:0]   io_rdata;
  logic [7:0]   xfer_tick = '0;
  logic [7:0]   ch_mask;
  logic [63:0]  ch_mode;
  logic [127:0] ch_iop;

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R12";

  // behavioural reference state
  logic [23:0] m_addr [8];
  logic [15:0] m_cnt  [8];
  logic [15:0] m_iop  [8];
  logic [7:0]  m_mode [8];
  logic [7:0]  m_mask, m_tc, m_rdata;
  int          m_op, m_ch, m_ptr;

  dma_prog_port u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .xfer_tick(xfer_tick),
    .ch_mask(ch_mask), .ch_mode(ch_mode), .ch_iop(ch_iop)
  );

  always #10 clk = ~clk;

  task automatic model_reset();
    for (int c = 0; c < 8; c++) begin
      m_addr[c] = '0; m_cnt[c] = '0; m_iop[c] = '0; m_mode[c] = '0;
    end
    m_mask = 8'hFF; m_tc = '0;
  endtask

  task automatic model_step(bit wr, bit rd, logic [7:0] a, logic [7:0] d, logic [7:0] tk);
    if (wr && a == 8'h18) begin
      m_op = int'(d[7:4]); m_ch = int'(d[2:0]); m_ptr = 0;
      if (m_op == 9)  m_mask[m_ch] = 1'b1;
      if (m_op == 10) m_mask[m_ch] = 1'b0;
      if (m_op == 13) model_reset();
    end else if (wr && a == 8'h1A) begin
      case (m_op)
        0: if (m_ptr < 2) m_iop[m_ch][m_ptr*8 +: 8] = d;
        2: if (m_ptr < 3) m_addr[m_ch][m_ptr*8 +: 8] = d;
        4: if (m_ptr < 2) m_cnt[m_ch][m_ptr*8 +: 8] = d;
        7: if (m_ptr == 0) m_mode[m_ch] = d;
        default: ;
      endcase
      if (m_ptr < 3) m_ptr++;
    end
    if (rd && !wr) begin
      m_rdata = '0;
      if (a == 8'h1A) begin
        case (m_op)
          3: if (m_ptr < 3) m_rdata = m_addr[m_ch][m_ptr*8 +: 8];
          5: if (m_ptr < 2) m_rdata = m_cnt[m_ch][m_ptr*8 +: 8];
          6: if (m_ptr == 0) begin m_rdata = m_tc; m_tc = '0; end
          default: ;
        endcase
        if (m_ptr < 3) m_ptr++;
      end
    end
    for (int c = 0; c < 8; c++)
      if (tk[c] && !m_mask[c] && m_mode[c][2]) begin
        if (m_cnt[c] == 16'h0) m_tc[c] = 1'b1;
        m_cnt[c]  = m_cnt[c] - 16'h1;
        m_addr[c] = m_addr[c] + 24'h1;
      end
  endtask

  task automatic compare();
    logic [63:0]  em;
    logic [127:0] ei;
    for (int c = 0; c < 8; c++) begin
      em[c*8 +: 8] = m_mode[c];
      ei[c*16 +: 16] = m_iop[c];
    end
    tests++;
    if (ch_mask !== m_mask || ch_mode !== em || ch_iop !== ei || io_rdata !== m_rdata) begin
      fails++;
      $display("FAIL %s: mask %h/%h mode %h/%h iop %h/%h rdata %h/%h (actual/expected)",
               cur_req, ch_mask, m_mask, ch_mode, em, ch_iop, ei, io_rdata, m_rdata);
    end
  endtask

  task automatic chk(logic [127:0] act, logic [127:0] exp, string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit wr, bit rd, logic [7:0] a, logic [7:0] d, logic [7:0] tk);
    io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d; xfer_tick = tk;
    @(posedge clk);
    model_step(wr, rd, a, d, tk);
    @(negedge clk);
    io_wr = 0; io_rd = 0; xfer_tick = '0;
    compare();
  endtask

  task automatic fnw(logic [7:0] d); cyc(1, 0, 8'h18, d, 8'h00); endtask
  task automatic exw(logic [7:0] d); cyc(1, 0, 8'h1A, d, 8'h00); endtask
  task automatic exr();              cyc(0, 1, 8'h1A, 8'h00, 8'h00); endtask
  task automatic tick(logic [7:0] t); cyc(0, 0, 8'h00, 8'h00, t); endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset(); m_rdata = '0; m_op = 15; m_ch = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    compare();                                   // R12 reset state
    cur_req = "R12";
    exw(8'h55); exw(8'h66);
    chk(ch_iop, 128'h0, "R12");

    cur_req = "R2";
    fnw(8'h23); exw(8'h12); exw(8'h34); exw(8'h56);
    fnw(8'h33);
    exr(); chk(io_rdata, 8'h12, "R2");
    exr(); chk(io_rdata, 8'h34, "R2");
    exr(); chk(io_rdata, 8'h56, "R2");
    exr(); chk(io_rdata, 8'h00, "R7");

    cur_req = "R1";
    fnw(8'h3B); exr(); chk(io_rdata, 8'h12, "R1");

    cur_req = "R3";
    fnw(8'h43); exw(8'hFE); exw(8'h01); exw(8'h77);
    fnw(8'h53);
    exr(); chk(io_rdata, 8'hFE, "R3");
    exr(); chk(io_rdata, 8'h01, "R3");
    exr(); chk(io_rdata, 8'h00, "R7");

    cur_req = "R4";
    fnw(8'h05); exw(8'hCD); exw(8'hAB); exw(8'hEE);
    chk(ch_iop[5*16 +: 16], 16'hABCD, "R4");

    cur_req = "R5";
    fnw(8'h75); exw(8'h4D); exw(8'h99);
    chk(ch_mode[5*8 +: 8], 8'h4D, "R5");

    cur_req = "R6";
    fnw(8'hA5); chk(ch_mask, 8'hDF, "R6");
    exw(8'h11); chk(ch_iop[5*16 +: 16], 16'hABCD, "R7");
    fnw(8'h95); chk(ch_mask, 8'hFF, "R6");

    cur_req = "R10";
    fnw(8'h43); exw(8'h02); exw(8'h00);
    fnw(8'h73); exw(8'h04);
    fnw(8'hA3);
    tick(8'h08); tick(8'h08);
    fnw(8'h63); exr(); chk(io_rdata, 8'h00, "R10");
    tick(8'h08);
    cur_req = "R11";
    fnw(8'h60); exr(); chk(io_rdata, 8'h08, "R11");
    exr(); chk(io_rdata, 8'h00, "R11");
    fnw(8'h60); exr(); chk(io_rdata, 8'h00, "R11");
    cur_req = "R10";
    fnw(8'h53); exr(); chk(io_rdata, 8'hFF, "R10"); exr(); chk(io_rdata, 8'hFF, "R10");
    cur_req = "R9";
    fnw(8'h33); exr(); chk(io_rdata, 8'h15, "R9");

    fnw(8'h93); tick(8'h08);
    fnw(8'h53); exr(); chk(io_rdata, 8'hFF, "R9");
    fnw(8'hA3); fnw(8'h73); exw(8'h00); tick(8'h08);
    fnw(8'h53); exr(); chk(io_rdata, 8'hFF, "R9");

    fnw(8'h21); exw(8'hFF); exw(8'hFF); exw(8'hFF);
    fnw(8'h41); exw(8'h00); exw(8'h00);
    fnw(8'h71); exw(8'h04); fnw(8'hA1);
    tick(8'h02);
    fnw(8'h31);
    exr(); chk(io_rdata, 8'h00, "R9");
    exr(); chk(io_rdata, 8'h00, "R9");
    exr(); chk(io_rdata, 8'h00, "R9");

    cur_req = "R11";
    fnw(8'h41); exw(8'h00); exw(8'h00);
    fnw(8'h61);
    cyc(0, 1, 8'h1A, 8'h00, 8'h02);
    chk(io_rdata, 8'h02, "R11");
    fnw(8'h61); exr(); chk(io_rdata, 8'h02, "R11");

    cur_req = "R8";
    fnw(8'h05); exw(8'h34); exw(8'h12);
    fnw(8'hD0);
    chk(ch_mask, 8'hFF, "R8");
    chk(ch_mode, 64'h0, "R8");
    chk(ch_iop, 128'h0, "R8");
    fnw(8'h31); exr(); chk(io_rdata, 8'h00, "R8");
    fnw(8'h60); exr(); chk(io_rdata, 8'h00, "R8");

    cur_req = "R7";
    for (int i = 0; i < 1500; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 2)      fnw(8'($urandom));
      else if (k < 5) exw(8'($urandom));
      else if (k < 8) cyc(0, 1, 8'h1A, 8'h00, 8'($urandom));
      else            tick(8'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule